// File: doc/BRIEF.md
# Converter Sample Offset and Gain Trim

This block sits downstream of a converter's decimation filter and trims each signed 24-bit sample. It first removes a programmable offset, then scales the difference by a programmable gain word, and finally clamps the scaled value back into the signed 24-bit range. Samples enter with a valid strobe and leave with a valid strobe after a fixed two-cycle pipeline.

The offset and gain words are each loaded one byte at a time through a small byte-addressed write port. The low and middle bytes are held in a staging area. A write to the high byte commits all three bytes to the live word at once, so a sample never sees a half-updated word. Each committed value applies to every sample captured after the committing clock edge.

Top module: `adc_trim_path`

## Requirements
- R1: After reset the live offset is 0 and the live gain is 400000h, so every sample leaves unchanged. During reset out_valid and out_data are 0.
- R2: The write port maps address 0, 1 and 2 to the offset low byte (bits 7:0), middle byte (bits 15:8) and high byte (bits 23:16). Addresses 3, 4 and 5 map to the same three bytes of the gain. Writes to addresses 6 and 7 have no effect.
- R3: A write to a low or middle byte changes only the staging area. A write to a high byte commits that byte, together with the two staged bytes, to the live word.
- R4: The offset is 24-bit two's complement and is subtracted from the sample in 25-bit signed arithmetic, so the difference never wraps.
- R5: The gain is unsigned, with 400000h equal to 1.0. The unclamped result is floor((sample − offset) × gain / 2^22).
- R6: A result above 7FFFFFh is output as 7FFFFFh.
- R7: A result below −800000h is output as 800000h.
- R8: Each in_valid pulse yields exactly one out_valid pulse two clock edges later. When there is no valid output, out_valid stays low and out_data holds its last value.
- R9: A committing high-byte write that shares a clock edge with a sample capture leaves that sample on the old word. The next captured sample uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Byte write strobe |
| cfg_addr | input | 3 | Byte address (0..2 offset, 3..5 gain) |
| cfg_wdata | input | 8 | Byte write data |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 24 | Signed corrected, clamped sample |

## Verification
A corrupted staging byte or live word appears on the first sample captured after the commit, two edges later, as an output that misses the arithmetic model. A sign or width error in the 25-bit difference or the wide product shows up only at the extreme offsets and samples, as a wrong or missing clamp. For this reason the sweep pairs every extreme offset with every extreme gain. A valid-pipeline fault shows at the ports within two cycles, as a missing, extra or shifted out_valid pulse.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;
  localparam int CFG_ADDR_W = 3;
  typedef enum logic [CFG_ADDR_W-1:0] {
    ADR_OFS_B0  = 3'd0,
    ADR_OFS_B1  = 3'd1,
    ADR_OFS_B2  = 3'd2,
    ADR_GAIN_B0 = 3'd3,
    ADR_GAIN_B1 = 3'd4,
    ADR_GAIN_B2 = 3'd5
  } trim_addr_e;
endpackage

// File: rtl/trim_word_reg.sv
module trim_word_reg #(
  parameter int NBYTES = 3,
  parameter int ADDR_W = 3,
  parameter int BASE = 0,
  parameter logic [8*NBYTES-1:0] RESET_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [8*NBYTES-1:0]   word,
  output logic                  commit_evt
);
  localparam int TOP = NBYTES - 1;

  logic [7:0]          stage_q [TOP];
  logic                hit;
  logic [ADDR_W-1:0]   rel;
  logic [8*NBYTES-1:0] next_word;
  logic [8*NBYTES-1:0] word_q;

  assign rel = addr - ADDR_W'(BASE);
  assign hit = wr_en && (int'(addr) >= BASE) && (int'(addr) < BASE + NBYTES);
  assign commit_evt = hit && (rel == ADDR_W'(TOP));

  for (genvar b = 0; b < TOP; b++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[b] <= '0;
      else if (hit && rel == ADDR_W'(b)) stage_q[b] <= wdata;
    end
  end

  always_comb begin
    next_word[8*TOP +: 8] = wdata;
    for (int b = 0; b < TOP; b++) next_word[8*b +: 8] = stage_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= RESET_VAL;
    else if (commit_evt) word_q <= next_word;
  end

  assign word = word_q;

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> word == RESET_VAL);
  assert_foreign_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> $stable(word));
  assert_staged_write_held_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !commit_evt) |=> $stable(word));
  assert_commit_top_byte_R3: assert property (@(posedge clk) disable iff (rst)
    commit_evt |=> word[8*TOP +: 8] == $past(wdata));
endmodule

// File: rtl/trim_sub_stage.sv
module trim_sub_stage #(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     v_in,
  input  logic [DATA_W-1:0]        sample,
  input  logic [DATA_W-1:0]        offset,
  input  logic [DATA_W-1:0]        gain,
  output logic                     v_q,
  output logic signed [DATA_W:0]   diff_q,
  output logic [DATA_W-1:0]        gain_q
);
  function automatic logic signed [DATA_W:0] f_diff(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return $signed({a[DATA_W-1], a}) - $signed({b[DATA_W-1], b});
  endfunction

  logic signed [DATA_W:0] diff_d;
  assign diff_d = f_diff(sample, offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      diff_q <= '0;
      gain_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        diff_q <= diff_d;
        gain_q <= gain;
      end
    end
  end

  assert_stage_valid_R8: assert property (@(posedge clk) disable iff (rst)
    v_in |=> v_q);
  assert_diff_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (v_in && !sample[DATA_W-1] && offset[DATA_W-1]) |=> !diff_q[DATA_W]);
endmodule

// File: rtl/trim_scale_sat.sv
module trim_scale_sat #(
  parameter int DATA_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_in,
  input  logic signed [DATA_W:0]  diff,
  input  logic [DATA_W-1:0]       gain,
  output logic                    q_valid,
  output logic [DATA_W-1:0]       q_data
);
  localparam int DIFF_W = DATA_W + 1;
  localparam int PROD_W = DIFF_W + DATA_W + 1;
  localparam int SHIFT  = DATA_W - 2;
  localparam logic signed [PROD_W-1:0] MAXV =
    {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MINV =
    {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [PROD_W-1:0] f_scale(
    input logic signed [DIFF_W-1:0] d, input logic [DATA_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    p = $signed(d) * $signed({1'b0, g});
    return p >>> SHIFT;
  endfunction

  logic signed [PROD_W-1:0] scaled;
  logic sat_pos, sat_neg;
  logic [DATA_W-1:0] clamped;

  assign scaled  = f_scale(diff, gain);
  assign sat_pos = scaled > MAXV;
  assign sat_neg = scaled < MINV;

  always_comb begin
    if (sat_pos)      clamped = OUT_MAX;
    else if (sat_neg) clamped = OUT_MIN;
    else              clamped = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= v_in;
      if (v_in) q_data <= clamped;
    end
  end

  assert_clip_high_R6: assert property (@(posedge clk) disable iff (rst)
    (v_in && sat_pos) |=> q_data == OUT_MAX);
  assert_clip_low_R7: assert property (@(posedge clk) disable iff (rst)
    (v_in && sat_neg) |=> q_data == OUT_MIN);
  assert_zero_gain_R5: assert property (@(posedge clk) disable iff (rst)
    (v_in && gain == '0) |=> q_data == '0);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> (!q_valid && $stable(q_data)));
endmodule

// File: rtl/adc_trim_path.sv
module adc_trim_path
  import adc_trim_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [CFG_ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]             cfg_wdata,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data
);
  localparam int NBYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] UNITY = DATA_W'(1) << (DATA_W - 2);

  logic [DATA_W-1:0] ofs_word, gain_word;
  logic ofs_commit, gain_commit;
  logic v1;
  logic signed [DATA_W:0] diff1;
  logic [DATA_W-1:0] gain1;

  trim_word_reg #(.NBYTES(NBYTES), .ADDR_W(CFG_ADDR_W), .BASE(int'(ADR_OFS_B0)),
                  .RESET_VAL('0)) u_ofs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .word(ofs_word), .commit_evt(ofs_commit));

  trim_word_reg #(.NBYTES(NBYTES), .ADDR_W(CFG_ADDR_W), .BASE(int'(ADR_GAIN_B0)),
                  .RESET_VAL(UNITY)) u_gain (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .word(gain_word), .commit_evt(gain_commit));

  trim_sub_stage #(.DATA_W(DATA_W)) u_sub (
    .clk(clk), .rst(rst), .v_in(in_valid), .sample(in_data),
    .offset(ofs_word), .gain(gain_word),
    .v_q(v1), .diff_q(diff1), .gain_q(gain1));

  trim_scale_sat #(.DATA_W(DATA_W)) u_scale (
    .clk(clk), .rst(rst), .v_in(v1), .diff(diff1), .gain(gain1),
    .q_valid(out_valid), .q_data(out_data));

  assert_two_cycle_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  assert_identity_trim_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ofs_word == '0 && gain_word == UNITY) |-> ##2 out_data == $past(in_data, 2));
  assert_single_commit_R3: assert property (@(posedge clk) disable iff (rst)
    !(ofs_commit && gain_commit));
endmodule

// File: tb/adc_trim_path_bench.sv
module adc_trim_path_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic out_valid;
  logic [23:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  longint exp_q[$];
  string tag_q[$];

  longint m_ofs = 0;
  longint m_gain = 64'h400000;
  logic [7:0] m_ost0 = 0, m_ost1 = 0, m_gst0 = 0, m_gst1 = 0;

  always #4 clk = ~clk;

  adc_trim_path u_adc_trim_path (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  function automatic longint s24(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint expect_of(input longint x, input longint o, input longint g);
    longint p, q;
    p = (x - o) * g;
    if (p >= 0) q = p / 4194304;
    else q = -((-p + 4194303) / 4194304);
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: m_ost0 = d;
      3'd1: m_ost1 = d;
      3'd2: m_ofs = s24({d, m_ost1, m_ost0});
      3'd3: m_gst0 = d;
      3'd4: m_gst1 = d;
      3'd5: m_gain = longint'({d, m_gst1, m_gst0});
      default: ;
    endcase
  endtask

  task automatic push(input longint x, input string tag);
    longint e;
    e = expect_of(x, m_ofs, m_gain);
    exp_q.push_back(e);
    if (e == 8388607 && tag == "R5") tag_q.push_back("R6");
    else if (e == -8388608 && tag == "R5") tag_q.push_back("R7");
    else tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic load(input longint o, input longint g);
    logic [23:0] ov, gv;
    ov = o[23:0]; gv = g[23:0];
    wr(3'd0, ov[7:0]); wr(3'd1, ov[15:8]); wr(3'd2, ov[23:16]);
    wr(3'd3, gv[7:0]); wr(3'd4, gv[15:8]); wr(3'd5, gv[23:16]);
  endtask

  task automatic send(input longint x, input string tag);
    @(negedge clk);
    cfg_wr = 1'b0;
    in_valid = 1'b1; in_data = x[23:0];
    push(x, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; cfg_wr = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8", 1, 0);
      end else begin
        longint e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, s24(out_data), e);
      end
    end
  end

  longint samples [12] = '{0, 1, -1, 8388607, -8388608, 4194304, -4194304,
                           1193046, -3355443, 8388606, -8388607, 12345};
  longint offs [7] = '{0, 1, -1, 8388607, -8388608, 1193046, -703710};
  longint gains [7] = '{64'h400000, 64'h800000, 64'h200000, 0,
                        64'hFFFFFF, 1, 64'h3FFFFF};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    check("R1", out_valid, 0);
    check("R1", out_data, 0);
    rst = 1'b0;

    // R1: reset words give pass-through
    for (int i = 0; i < 12; i++) send(samples[i], "R1");
    idle(3);

    // R8: exact latency of a single pulse
    send(777, "R8");
    @(negedge clk); in_valid = 1'b0;
    check("R8", out_valid, 0);
    @(negedge clk);
    check("R8", out_valid, 1);
    idle(3);
    held = out_data;
    idle(4);
    check("R8", out_valid, 0);
    check("R8", out_data, held);

    // R4/R5/R6/R7: sweep offsets x gains x samples
    foreach (offs[a]) begin
      foreach (gains[b]) begin
        load(offs[a], gains[b]);
        for (int i = 0; i < 12; i++) send(samples[i], (a > 2) ? "R4" : "R5");
        idle(1);
      end
    end
    idle(3);

    // R3: staged bytes do not alter live offset
    load(0, 64'h400000);
    wr(3'd0, 8'h10); wr(3'd1, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    send(1000, "R3"); send(-5000, "R3");
    idle(3);
    wr(3'd2, 8'h00);
    send(1000, "R3"); send(-5000, "R3");
    wr(3'd5, 8'h20);
    send(1000, "R3"); send(-5000, "R3");
    idle(3);

    // R2: addresses 6 and 7 ignored
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    send(4096, "R2"); send(-4096, "R2");
    idle(3);

    // R9: commit sharing an edge with a capture
    load(0, 64'h400000);
    wr(3'd0, 8'h64); wr(3'd1, 8'h00);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'd2; cfg_wdata = 8'h00;
    in_valid = 1'b1; in_data = 24'd5000;
    push(5000, "R9");
    model_write(3'd2, 8'h00);
    send(5000, "R9");
    idle(4);

    check("R8", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule